// File: doc/BRIEF.md
# Dual-Buffer DMA Request Controller

This block paces a converter sample stream onto two system DMA request channels used as a ping-pong pair. While the host services one memory buffer, the other buffer fills or drains. A host control register picks the pacing source: software only, the A/D clock, the D/A clock or the A/D external trigger. Each pacing tick raises one request on the channel that owns the active buffer. The request is held until the DMA engine acknowledges it, and every acknowledge moves one 2-byte sample.

When the DMA engine signals terminal count together with an acknowledge, the buffer is finished. A sticky done flag is set, which also drives the interrupt, and the active buffer index flips to the other channel. With dual mode off, the block stops requesting after the first finished buffer. The host clears the done flag by writing a one to a command bit of the same register. Init commands and a buffer-reset command put the sequencing back to buffer 0.

Top module: `dbdma_top`

## Requirements
- R1: Control bits 11:10 select the pacing source: 0 = software (no requests), 1 = `ad_clk_tick`, 2 = `da_clk_tick`, 3 = `ad_trig_tick`. Ticks from unselected sources have no effect on `dma_req`.
- R2: A selected tick raises `dma_req[i]`, where i is the active buffer index read back at bit 9. The request stays high until `dma_ack[i]` arrives. An acknowledge on the other channel has no effect, and at most one request bit is high at a time.
- R3: Each accepted acknowledge adds 2 to the byte count of the active channel (`buf0_bytes`, `buf1_bytes`).
- R4: An accepted acknowledge with `dma_tc[i]` high ends the buffer. The done flag at read bit 15 is then set and `irq` rises.
- R5: Writing a one to bit 13 clears the done flag. A write with bit 13 low leaves it set. Bit 13 reads as 0.
- R6: Each buffer end toggles the active index between 0 and 1 and clears the byte count of the newly active channel.
- R7: Bit 12 enables dual mode. With it off, no request is raised after the first buffer end until an init or buffer-reset command.
- R8: Writing a one to bit 6 (A/D init) or bit 5 (D/A init) clears the done flag, the overrun flag, any pending request, both byte counts and the active index.
- R9: Writing a one to bit 9 resets the active index to 0, drops any pending request and clears both byte counts.
- R10: A selected tick that arrives while a request is still unacknowledged sets the sticky overrun flag at read bit 8. Bit 14 enables the overrun flag onto `irq`, and `irq` = done OR (bit 14 AND overrun).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Control register write strobe |
| host_wdata | input | 16 | Control write data |
| host_rdata | output | 16 | Control/status readback |
| ad_clk_tick | input | 1 | A/D clock sample strobe |
| da_clk_tick | input | 1 | D/A clock sample strobe |
| ad_trig_tick | input | 1 | A/D external trigger strobe |
| dma_req | output | 2 | DMA request, one bit per channel |
| dma_ack | input | 2 | DMA acknowledge, one bit per channel |
| dma_tc | input | 2 | Terminal count, one bit per channel |
| buf0_bytes | output | CNT_W | Bytes moved in buffer 0 |
| buf1_bytes | output | CNT_W | Bytes moved in buffer 1 |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `CNT_W` = 8 and the default 2-byte sample. This keeps the count ports small while leaving every count the bench produces far below wrap. Buffer lengths are set by when the bench raises terminal count, so buffers of one and of three samples are both covered. These lengths bring the single-buffer halt and both ping-pong directions into reach within a few dozen cycles.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;
  localparam int NUM_CH   = 2;
  localparam int REG_W    = 16;
  localparam int B_DONE   = 15;
  localparam int B_ERREN  = 14;
  localparam int B_CLR    = 13;
  localparam int B_DUAL   = 12;
  localparam int B_SRC_LO = 10;
  localparam int B_BUFRST = 9;
  localparam int B_OVR    = 8;
  localparam int B_ADINIT = 6;
  localparam int B_DAINIT = 5;

  typedef enum logic [1:0] {
    SRC_SW     = 2'd0,
    SRC_ADCLK  = 2'd1,
    SRC_DACLK  = 2'd2,
    SRC_ADTRIG = 2'd3
  } src_e;

  typedef struct packed {
    logic err_en;
    logic dual;
    src_e src;
  } cfg_t;
endpackage

// File: rtl/dbdma_ctrl_reg.sv
module dbdma_ctrl_reg
  import dbdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             buf_end,
  output cfg_t             cfg,
  output logic             done,
  output logic             init_cmd,
  output logic             bufrst_cmd
);
  cfg_t cfg_q, cfg_d;
  logic done_q, done_d;
  logic clr_cmd;
  logic unused_wbits;

  assign unused_wbits = ^{wdata[B_DONE], wdata[B_OVR], wdata[7], wdata[4:0]};
  assign init_cmd   = wr_en & (wdata[B_ADINIT] | wdata[B_DAINIT]);
  assign bufrst_cmd = wr_en & wdata[B_BUFRST];
  assign clr_cmd    = wr_en & wdata[B_CLR];

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      cfg_d.err_en = wdata[B_ERREN];
      cfg_d.dual   = wdata[B_DUAL];
      cfg_d.src    = src_e'(wdata[B_SRC_LO+1:B_SRC_LO]);
    end
    done_d = done_q;
    if (init_cmd)     done_d = 1'b0;
    else if (buf_end) done_d = 1'b1;
    else if (clr_cmd) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_d;
      done_q <= done_d;
    end
  end

  assign cfg  = cfg_q;
  assign done = done_q;

  // R5: done is sticky until a clear or init command
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !clr_cmd && !init_cmd |=> done_q);
  // R4: a buffer end always leaves done set
  assert_done_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    buf_end && !init_cmd |=> done_q);
endmodule

// File: rtl/dbdma_req_engine.sv
module dbdma_req_engine
  import dbdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              cfg,
  input  logic              ad_clk_tick,
  input  logic              da_clk_tick,
  input  logic              ad_trig_tick,
  input  logic [NUM_CH-1:0] dack,
  input  logic [NUM_CH-1:0] tc,
  input  logic              init_cmd,
  input  logic              bufrst_cmd,
  output logic [NUM_CH-1:0] dreq,
  output logic              active,
  output logic              ack_ok,
  output logic              buf_end,
  output logic              overrun
);
  logic pend_q, pend_d;
  logic act_q, act_d;
  logic halt_q, halt_d;
  logic ovr_q, ovr_d;
  logic tick, tick_ok;

  always_comb begin
    unique case (cfg.src)
      SRC_ADCLK:  tick = ad_clk_tick;
      SRC_DACLK:  tick = da_clk_tick;
      SRC_ADTRIG: tick = ad_trig_tick;
      default:    tick = 1'b0;
    endcase
  end

  assign ack_ok  = pend_q & dack[act_q];
  assign buf_end = ack_ok & tc[act_q];
  assign tick_ok = tick & ~halt_q & ~(buf_end & ~cfg.dual);

  always_comb begin
    pend_d = (pend_q & ~ack_ok) | tick_ok;
    act_d  = act_q ^ buf_end;
    halt_d = halt_q | (buf_end & ~cfg.dual);
    ovr_d  = ovr_q | (tick_ok & pend_q & ~ack_ok);
    if (init_cmd || bufrst_cmd) begin
      pend_d = 1'b0;
      act_d  = 1'b0;
      halt_d = 1'b0;
    end
    if (init_cmd) ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      halt_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
      halt_q <= halt_d;
      ovr_q  <= ovr_d;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_req
    assign dreq[c] = pend_q & (act_q == c[0]);
  end

  assign active  = act_q;
  assign overrun = ovr_q;

  // R2: never two requests at once
  assert_req_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dreq));
  // R2: an unacknowledged request is held
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|dreq) && !(|(dreq & dack)) && !init_cmd && !bufrst_cmd |=> $stable(dreq));
  // R6: buffer end flips the active index
  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_end && !init_cmd && !bufrst_cmd |=> active != $past(active));
  // R7: single-buffer mode stops after the first buffer end
  assert_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_end && !cfg.dual && !init_cmd && !bufrst_cmd |=> dreq == '0);
endmodule

// File: rtl/dbdma_byte_ctr.sv
module dbdma_byte_ctr #(
  parameter int CNT_W = 16,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = clr | inc;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + STEP_V;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R3: one accepted transfer adds one sample's bytes
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !clr |=> count == $past(count) + STEP_V);
  // R8: cleared counter reads zero
  assert_count_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
endmodule

// File: rtl/dbdma_top.sv
module dbdma_top
  import dbdma_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int SAMPLE_BYTES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr,
  input  logic [15:0]      host_wdata,
  output logic [15:0]      host_rdata,
  input  logic             ad_clk_tick,
  input  logic             da_clk_tick,
  input  logic             ad_trig_tick,
  output logic [1:0]       dma_req,
  input  logic [1:0]       dma_ack,
  input  logic [1:0]       dma_tc,
  output logic [CNT_W-1:0] buf0_bytes,
  output logic [CNT_W-1:0] buf1_bytes,
  output logic             irq
);
  cfg_t             cfg;
  logic             done, init_cmd, bufrst_cmd;
  logic             active, ack_ok, buf_end, overrun;
  logic [CNT_W-1:0] counts [NUM_CH];

  dbdma_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .wdata(host_wdata),
    .buf_end(buf_end), .cfg(cfg), .done(done),
    .init_cmd(init_cmd), .bufrst_cmd(bufrst_cmd)
  );

  dbdma_req_engine u_eng (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .ad_clk_tick(ad_clk_tick), .da_clk_tick(da_clk_tick),
    .ad_trig_tick(ad_trig_tick), .dack(dma_ack), .tc(dma_tc),
    .init_cmd(init_cmd), .bufrst_cmd(bufrst_cmd), .dreq(dma_req),
    .active(active), .ack_ok(ack_ok), .buf_end(buf_end), .overrun(overrun)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
    logic mine, becomes_mine;
    assign mine         = (active == c[0]);
    assign becomes_mine = buf_end & ~mine;
    dbdma_byte_ctr #(.CNT_W(CNT_W), .STEP(SAMPLE_BYTES)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .clr(init_cmd | bufrst_cmd | becomes_mine),
      .inc(ack_ok & mine),
      .count(counts[c])
    );
  end

  assign buf0_bytes = counts[0];
  assign buf1_bytes = counts[1];

  always_comb begin
    host_rdata                         = '0;
    host_rdata[B_DONE]                 = done;
    host_rdata[B_ERREN]                = cfg.err_en;
    host_rdata[B_DUAL]                 = cfg.dual;
    host_rdata[B_SRC_LO+1:B_SRC_LO]    = cfg.src;
    host_rdata[B_BUFRST]               = active;
    host_rdata[B_OVR]                  = overrun;
  end

  assign irq = done | (cfg.err_en & overrun);

  // R10: overrun alone raises irq only when enabled
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !cfg.err_en |-> !irq);
endmodule

// File: tb/dbdma_top_tb_top.sv
module dbdma_top_tb_top;
  localparam int CW = 8;
  localparam int NV = 29;
  // kinds: 0 write, 1 A/D clk, 2 D/A clk, 3 A/D trig, 4 ack(arg0=ch,arg1=tc), 5 idle
  // vector: kind[3] arg[16] rdata[16] dreq[2] irq[1] req[4]
  localparam logic [41:0] VEC [NV] = '{
    {3'd0,16'h0400,16'h0400,2'b00,1'b0,4'd1},  // R1 src A/D clk
    {3'd2,16'h0000,16'h0400,2'b00,1'b0,4'd1},  // R1 other tick ignored
    {3'd3,16'h0000,16'h0400,2'b00,1'b0,4'd1},  // R1
    {3'd1,16'h0000,16'h0400,2'b01,1'b0,4'd1},  // R1
    {3'd5,16'h0000,16'h0400,2'b01,1'b0,4'd2},  // R2 held
    {3'd4,16'h0001,16'h0400,2'b01,1'b0,4'd2},  // R2 wrong ack
    {3'd4,16'h0000,16'h0400,2'b00,1'b0,4'd2},  // R2
    {3'd1,16'h0000,16'h0400,2'b01,1'b0,4'd2},  // R2
    {3'd1,16'h0000,16'h0500,2'b01,1'b0,4'd10}, // R10 overrun
    {3'd4,16'h0002,16'h8700,2'b00,1'b1,4'd4},  // R4
    {3'd1,16'h0000,16'h8700,2'b00,1'b1,4'd7},  // R7 halted
    {3'd0,16'h0400,16'h8700,2'b00,1'b1,4'd5},  // R5 no clear
    {3'd0,16'h2400,16'h0700,2'b00,1'b0,4'd5},  // R5 clear
    {3'd0,16'h4400,16'h4700,2'b00,1'b1,4'd10}, // R10 enable
    {3'd0,16'h5440,16'h5400,2'b00,1'b0,4'd8},  // R8 init
    {3'd1,16'h0000,16'h5400,2'b01,1'b0,4'd2},  // R2
    {3'd4,16'h0002,16'hD600,2'b00,1'b1,4'd6},  // R6
    {3'd1,16'h0000,16'hD600,2'b10,1'b1,4'd6},  // R6 channel 1
    {3'd4,16'h0003,16'hD400,2'b00,1'b1,4'd6},  // R6 back to 0
    {3'd0,16'h7800,16'h5800,2'b00,1'b0,4'd1},  // R1 src D/A clk
    {3'd1,16'h0000,16'h5800,2'b00,1'b0,4'd1},  // R1
    {3'd2,16'h0000,16'h5800,2'b01,1'b0,4'd1},  // R1
    {3'd4,16'h0002,16'hDA00,2'b00,1'b1,4'd4},  // R4
    {3'd0,16'h7A00,16'h5800,2'b00,1'b0,4'd9},  // R9
    {3'd0,16'h1C00,16'h1C00,2'b00,1'b0,4'd1},  // R1 src trig
    {3'd3,16'h0000,16'h1C00,2'b01,1'b0,4'd1},  // R1
    {3'd0,16'h1C20,16'h1C00,2'b00,1'b0,4'd8},  // R8 D/A init
    {3'd0,16'h0000,16'h0000,2'b00,1'b0,4'd1},  // R1 software
    {3'd1,16'h0000,16'h0000,2'b00,1'b0,4'd1}   // R1
  };

  logic clk, rst_n, host_wr, ad_clk_tick, da_clk_tick, ad_trig_tick, irq;
  logic [15:0] host_wdata, host_rdata;
  logic [1:0] dma_req, dma_ack, dma_tc;
  logic [CW-1:0] buf0_bytes, buf1_bytes;
  int total, bad;
  bit finished;

  dbdma_top #(.CNT_W(CW), .SAMPLE_BYTES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ad_clk_tick(ad_clk_tick),
    .da_clk_tick(da_clk_tick), .ad_trig_tick(ad_trig_tick),
    .dma_req(dma_req), .dma_ack(dma_ack), .dma_tc(dma_tc),
    .buf0_bytes(buf0_bytes), .buf1_bytes(buf1_bytes), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic step(input logic [2:0] kind, input logic [15:0] arg);
    host_wr = (kind == 3'd0);
    host_wdata = arg;
    ad_clk_tick = (kind == 3'd1);
    da_clk_tick = (kind == 3'd2);
    ad_trig_tick = (kind == 3'd3);
    dma_ack = (kind == 3'd4) ? (arg[0] ? 2'b10 : 2'b01) : 2'b00;
    dma_tc = (kind == 3'd4 && arg[1]) ? (arg[0] ? 2'b10 : 2'b01) : 2'b00;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = '0; ad_clk_tick = 1'b0;
    da_clk_tick = 1'b0; ad_trig_tick = 1'b0; dma_ack = '0; dma_tc = '0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0; host_wr = 1'b0; host_wdata = '0; ad_clk_tick = 1'b0;
    da_clk_tick = 1'b0; ad_trig_tick = 1'b0; dma_ack = '0; dma_tc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset rdata", 32'(host_rdata), 32'h0);
    chk("reset dreq R2", 32'(dma_req), 32'h0);
    chk("reset irq R4", 32'(irq), 32'h0);
    chk("reset bytes R3", {buf1_bytes, buf0_bytes}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      string tg;
      v = VEC[i];
      step(v[41:39], v[38:23]);
      tg = $sformatf("vec%0d R%0d", i, v[3:0]);
      chk({tg, " rdata"}, 32'(host_rdata), 32'(v[22:7]));
      chk({tg, " dreq"}, 32'(dma_req), 32'(v[6:5]));
      chk({tg, " irq"}, 32'(irq), 32'(v[4]));
    end

    // byte counts: dual mode, A/D clock, init
    step(3'd0, 16'h1440);
    step(3'd1, 0); step(3'd4, 16'h0000);
    step(3'd1, 0); step(3'd4, 16'h0000);
    chk("R3 two samples", 32'(buf0_bytes), 32'd4);
    step(3'd1, 0); step(3'd4, 16'h0002);
    chk("R3 three samples", 32'(buf0_bytes), 32'd6);
    chk("R6 new buffer zero", 32'(buf1_bytes), 32'd0);
    chk("R6 active index", 32'(host_rdata[9]), 32'd1);
    step(3'd1, 0); step(3'd4, 16'h0001);
    chk("R3 chan1 count", 32'(buf1_bytes), 32'd2);
    chk("R3 chan0 kept", 32'(buf0_bytes), 32'd6);
    step(3'd0, 16'h1440);
    chk("R8 counts cleared", {buf1_bytes, buf0_bytes}, 32'h0);
    chk("R8 index cleared", 32'(host_rdata[9]), 32'd0);
    step(3'd1, 0); step(3'd4, 16'h0000);
    chk("R3 after init", 32'(buf0_bytes), 32'd2);
    step(3'd0, 16'h1600);
    chk("R9 counts cleared", {buf1_bytes, buf0_bytes}, 32'h0);
    // terminal count without acknowledge is ignored
    step(3'd1, 0);
    dma_tc = 2'b01;
    @(negedge clk);
    dma_tc = 2'b00;
    chk("R4 tc without ack", 32'(host_rdata[15]), 32'd0);
    chk("R2 request kept", 32'(dma_req), 32'h1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule